// File: doc/BRIEF.md
# Power-Down Wake Delay Controller

This block decides when a small processor may sleep and when it may run again. Software requests sleep by writing a power-down bit. The block then enters its sleep state and drops both the oscillator enable and the CPU clock enable, so every clock in the system stops. It leaves sleep on one of two events. The first is a hardware reset. The second is an external interrupt line that is asserted (active low), enabled, and configured for level triggering. An asserted edge-mode line, or one that is disabled, cannot wake the block.

Detecting a wake does not need a running clock. The oscillator enable rises combinationally as soon as a qualifying interrupt level appears. Once the oscillator runs, the block enters a settle phase. In that phase it counts oscillator cycles until the selected settle length has passed, and only then does it release the CPU clock. A two-bit select chooses one of four settle lengths, and it resets to the shortest. Reset itself also starts a settle phase, using the default length.

Top module: `pwr_wake_ctl`

## Requirements
- R1: While reset is held, osc_en is 1 and cpu_clk_en, ready and pd_bit are 0. After reset is released, cpu_clk_en rises on the 2048th oscillator rising edge, because the select resets to 00.
- R2: A pd_req sampled high while cpu_clk_en is 1 sets pd_bit and clears cpu_clk_en and osc_en at that same edge, provided no interrupt qualifies for wake.
- R3: In sleep, driving ext_int_n[i] to 0 while int_en[i]=1 and int_lvl[i]=1 raises osc_en without any clock edge. The first oscillator edge after that enters the settle phase.
- R4: In sleep, an asserted line whose int_en is 0, or whose int_lvl is 0 (edge mode), leaves osc_en at 0, and no clock edge occurs.
- R5: The settle length is set by the select written through dly_wr/dly_val: 00 gives 2048 cycles, 01 gives 8192, 10 gives 32768 and 11 gives 131072. After a wake, cpu_clk_en rises on the edge numbered length+1, counted from the wake.
- R6: cpu_clk_en stays 0 for the whole settle phase, until the selected length has elapsed.
- R7: On the edge that returns the block to run, ready is 1 for exactly one cycle and pd_bit clears.
- R8: A hardware reset during the settle phase restarts the count with the 2048-cycle default, whatever select was programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, which runs only while osc_en is 1 |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| pd_req | input | 1 | Request to set the power-down bit |
| dly_wr | input | 1 | Write strobe for the settle select |
| dly_val | input | 2 | Settle select value to write |
| ext_int_n | input | 4 | External interrupt lines, active low |
| int_en | input | 4 | Per-line enable |
| int_lvl | input | 4 | Per-line trigger type: 1 for level, 0 for edge |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| ready | output | 1 | One-cycle pulse when the block returns to run |
| pd_bit | output | 1 | Power-down bit, which clears automatically on return to run |

## Verification
The bound checker watches the behaviour that must hold on every cycle. It confirms that the CPU clock stays gated while the power-down bit is set, that ready is a single-cycle pulse aligned with the release of the CPU clock, that a sleep request from run gates the clocks at once, and that no release comes before at least the default settle length. Some behaviour only the directed scenarios can show. These are the exact edge counts for each select code, the rejection of disabled or edge-mode interrupts while the clock is stopped, and the fall back to the default length when reset arrives during settle.

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl #(
  parameter int N_INT     = 4,
  parameter int BASE_LOG2 = 11,
  parameter int STEP_LOG2 = 2,
  parameter int CNT_W     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             dly_wr,
  input  logic [1:0]       dly_val,
  input  logic [N_INT-1:0] ext_int_n,
  input  logic [N_INT-1:0] int_en,
  input  logic [N_INT-1:0] int_lvl,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             ready,
  output logic             pd_bit
);
  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_SETTLE} state_t;

  state_t           state;
  logic [1:0]       dly_sel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             wake;

  assign wake       = |(~ext_int_n & int_en & int_lvl);
  assign osc_en     = (state != S_SLEEP) | wake;
  assign cpu_clk_en = (state == S_RUN);

  always_comb begin
    int unsigned shamt;
    shamt = BASE_LOG2 + STEP_LOG2 * int'(dly_sel);
    term  = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_SETTLE;
      cnt     <= '0;
      dly_sel <= 2'b00;
      pd_bit  <= 1'b0;
      ready   <= 1'b0;
    end else begin
      ready <= 1'b0;
      if (dly_wr) dly_sel <= dly_val;
      case (state)
        S_RUN: if (pd_req) begin
          state  <= S_SLEEP;
          pd_bit <= 1'b1;
        end
        S_SLEEP: if (wake) begin
          state <= S_SETTLE;
          cnt   <= '0;
        end
        S_SETTLE: if (cnt == term) begin
          state  <= S_RUN;
          cnt    <= '0;
          pd_bit <= 1'b0;
          ready  <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: state <= S_RUN;
      endcase
    end
  end
endmodule

module pwr_wake_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_req,
  input logic osc_en,
  input logic cpu_clk_en,
  input logic ready,
  input logic pd_bit
);
  logic [31:0] gated_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gated_cnt <= '0;
    else if (cpu_clk_en) gated_cnt <= '0;
    else                 gated_cnt <= gated_cnt + 32'd1;
  end

  p_pd_gates_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_bit |-> !cpu_clk_en);
  p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_ready_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cpu_clk_en && !pd_bit));
  p_release_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> ready);
  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && pd_req) |=> (pd_bit && !cpu_clk_en));
  p_min_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> (gated_cnt >= 32'd2048));
  p_osc_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> osc_en);
endmodule

bind pwr_wake_ctl pwr_wake_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .osc_en(osc_en),
  .cpu_clk_en(cpu_clk_en), .ready(ready), .pd_bit(pd_bit)
);

// File: tb/pwr_wake_ctl_test.sv
module pwr_wake_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_req = 1'b0;
  logic       dly_wr = 1'b0;
  logic [1:0] dly_val = 2'b00;
  logic [3:0] ext_int_n = 4'hF;
  logic [3:0] int_en = 4'b1101;
  logic [3:0] int_lvl = 4'b1011;
  logic       osc_en, cpu_clk_en, ready, pd_bit;
  int         checks = 0;
  int         fails = 0;
  int         edges = 0;

  pwr_wake_ctl uut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .dly_wr(dly_wr), .dly_val(dly_val),
    .ext_int_n(ext_int_n), .int_en(int_en), .int_lvl(int_lvl),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .ready(ready), .pd_bit(pd_bit)
  );

  always begin
    #4;
    clk = osc_en ? ~clk : 1'b0;
  end

  always @(posedge clk) edges++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(input string tag, input int exp);
    int n = 0;
    while (!cpu_clk_en && n < 140000) begin
      @(posedge clk);
      n++;
      #1;
    end
    check(n == exp, tag, n, exp);
    check(ready == 1'b1, "R7 ready at release", int'(ready), 1);
    check(pd_bit == 1'b0, "R7 pd_bit cleared", int'(pd_bit), 0);
    @(posedge clk); #1;
    check(ready == 1'b0, "R7 ready one cycle", int'(ready), 0);
  endtask

  task automatic write_sel(input logic [1:0] v);
    @(posedge clk); #2;
    dly_wr = 1'b1; dly_val = v;
    @(posedge clk); #2;
    dly_wr = 1'b0;
  endtask

  task automatic enter_sleep();
    @(posedge clk); #2;
    pd_req = 1'b1;
    @(posedge clk); #1;
    pd_req = 1'b0;
    #1;
    check(pd_bit == 1'b1, "R2 pd_bit set", int'(pd_bit), 1);
    check(cpu_clk_en == 1'b0, "R2 cpu gated", int'(cpu_clk_en), 0);
    check(osc_en == 1'b0, "R2 osc stopped", int'(osc_en), 0);
  endtask

  task automatic t_reset();
    #20;
    check(osc_en == 1'b1, "R1 reset osc_en", int'(osc_en), 1);
    check(cpu_clk_en == 1'b0, "R1 reset cpu_clk_en", int'(cpu_clk_en), 0);
    check(pd_bit == 1'b0, "R1 reset pd_bit", int'(pd_bit), 0);
    check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    measure("R1 default settle after reset", 2048);
  endtask

  task automatic t_ignored();
    int e0;
    enter_sleep();
    e0 = edges;
    #50 ext_int_n[1] = 1'b0;
    #100;
    check(osc_en == 1'b0, "R4 disabled line ignored", int'(osc_en), 0);
    ext_int_n[1] = 1'b1;
    #20 ext_int_n[2] = 1'b0;
    #100;
    check(osc_en == 1'b0, "R4 edge-mode line ignored", int'(osc_en), 0);
    check(edges == e0, "R4 no clock edges", edges - e0, 0);
    ext_int_n[2] = 1'b1;
    #20;
  endtask

  task automatic t_wake(input logic [1:0] sel, input int line, input int len, input string tag);
    write_sel(sel);
    enter_sleep();
    #40 ext_int_n[line] = 1'b0;
    #1;
    check(osc_en == 1'b1, "R3 wake raises osc_en", int'(osc_en), 1);
    measure(tag, len + 1);
    ext_int_n[line] = 1'b1;
  endtask

  task automatic t_reset_in_settle();
    write_sel(2'b01);
    enter_sleep();
    #40 ext_int_n[3] = 1'b0;
    repeat (300) @(posedge clk);
    #1;
    check(cpu_clk_en == 1'b0, "R6 gated mid-settle", int'(cpu_clk_en), 0);
    ext_int_n[3] = 1'b1;
    #1 rst_n = 1'b0;
    #10;
    check(osc_en == 1'b1, "R8 osc on in reset", int'(osc_en), 1);
    check(cpu_clk_en == 1'b0, "R8 cpu gated in reset", int'(cpu_clk_en), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    measure("R8 reset restarts default settle", 2048);
  endtask

  initial begin
    t_reset();
    t_ignored();
    ext_int_n[0] = 1'b0;
    #1;
    check(osc_en == 1'b1, "R3 wake raises osc_en", int'(osc_en), 1);
    measure("R5 wake after ignored lines sel 00", 2049);
    ext_int_n[0] = 1'b1;
    t_wake(2'b01, 0, 8192, "R5 sel 01 length");
    t_wake(2'b11, 3, 131072, "R5 sel 11 length");
    t_wake(2'b00, 0, 2048, "R5 sel 00 length");
    t_reset_in_settle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 400000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule